// File: doc/BRIEF.md
# Model-Specific Register Access Router

This block sits between the instruction pipeline and a bank of model-specific registers. Each request is a single-cycle pulse. It carries a 32-bit index, a read/write flag, a 64-bit write value split into upper and lower 32-bit halves, the current privilege level and a set of feature-enable inputs. One cycle later the block answers with a done strobe, a fault flag and 64 bits of read data, again split into two 32-bit halves.

Before any register changes, the block applies its checks in a fixed order:

1. Privilege.
2. Steering of the APIC register window.
3. Feature gating.
4. Handling of unknown indices.
5. Per-register write rules.

Requests in the APIC window go out on a separate combinational port. The block holds only a few registers of its own:

- a feature-control word that becomes read-only once its lock bit is set;
- a system-call target address that must be canonical;
- a parameterised row of read-only capability words.

Top module: `msr_router`

## Requirements
- R1: A request at any privilege level other than 0 faults, returns zero data, drives no APIC request and changes no register.
- R2: Write data is the 64-bit value {wr_hi, wr_lo}. Read data comes back as rd_hi (bits 63:32) and rd_lo (bits 31:0). A faulting response carries zero read data.
- R3: When `feat_x2apic` is 1, indices 0x800 to 0xBFF go to the APIC port only if `apic_x2_mode` (bit 10 of the APIC base register) is 1.
  - On that path the response carries the APIC's read data and fault.
  - With `apic_x2_mode` at 0 the access faults and the APIC port stays idle.
  - When `feat_x2apic` is 0 those indices are unknown.
- R4: A register whose feature input is 0 is treated as unknown.
  - The feature-control word and the capability words are gated by `feat_virt`.
  - The system-call target (index 0xC0000082) is gated by `feat_sysc`.
- R5: An unknown index faults when `ignore_unknown` is 0. When `ignore_unknown` is 1, a read returns zero without a fault and a write is dropped without a fault.
- R6: The feature-control word (index 0x3A) stores only the low 32 bits of a write and reads back with zero upper bits. Once its bit 0 is 1, every write to it faults and leaves it unchanged. Reset clears it to zero.
- R7: Capability word k sits at index CAP_BASE+k (default 0x480, four words). It reads as {32'h5A5A0000+k, 32'h00000F00+k}, and every write to it faults.
- R8: A write to the system-call target faults and leaves it unchanged unless bits 63:47 of the value are all equal. A canonical value is stored in full. Reset clears it to zero.
- R9: `rsp_done` is 1 exactly in the cycle after each `req_valid` pulse and 0 otherwise. `rsp_fault` and the read data are valid while `rsp_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Single-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index |
| wr_hi | input | 32 | Write value bits 63:32 |
| wr_lo | input | 32 | Write value bits 31:0 |
| req_priv | input | 2 | Current privilege level |
| feat_x2apic | input | 1 | Enables the APIC register window |
| feat_sysc | input | 1 | Enables the system-call target register |
| feat_virt | input | 1 | Enables feature-control and capability words |
| ignore_unknown | input | 1 | Suppresses faults on unknown indices |
| apic_x2_mode | input | 1 | Bit 10 of the APIC base register |
| apic_req | output | 1 | Request to the APIC port |
| apic_we | output | 1 | APIC write flag |
| apic_index | output | 32 | Index sent to the APIC |
| apic_wdata | output | 64 | Write value sent to the APIC |
| apic_rdata | input | 64 | APIC read data, same cycle |
| apic_fault | input | 1 | APIC fault, same cycle |
| rsp_done | output | 1 | Response strobe |
| rsp_fault | output | 1 | Access faulted |
| rd_hi | output | 32 | Read data bits 63:32 |
| rd_lo | output | 32 | Read data bits 31:0 |

## Verification
The same indices are accessed at privilege levels 0, 2 and 3. This separates the privilege fault from every later check.

The APIC window is probed under all three settings of the window-enable and mode inputs, including an index for which the APIC itself faults. That shows steering, denial and the fall-through to unknown-index handling are distinct paths.

Feature inputs and `ignore_unknown` are toggled around reads and writes of the stored registers. Readback after a re-enable reveals whether a dropped write leaked into storage.

Address values sit just on either side of the canonical boundary. The lock bit is set, and then a clearing write is attempted.

// File: rtl/msr_rtr_pkg.sv
package msr_rtr_pkg;

    localparam int IDX_W   = 32;
    localparam int DATA_W  = 64;
    localparam int PRIV_W  = 2;
    localparam int VA_BITS = 48;

    localparam logic [IDX_W-1:0] IDX_FEAT_CTL   = 32'h0000_003A;
    localparam logic [IDX_W-1:0] IDX_SYS_TARGET = 32'hC000_0082;
    localparam logic [IDX_W-1:0] APIC_WIN_LO    = 32'h0000_0800;
    localparam logic [IDX_W-1:0] APIC_WIN_HI    = 32'h0000_0BFF;

    typedef enum logic [2:0] {
        TGT_PRIV_DENY,
        TGT_APIC,
        TGT_APIC_DENY,
        TGT_FEAT_CTL,
        TGT_SYS_TARGET,
        TGT_CAP,
        TGT_UNKNOWN
    } target_e;

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
    } word64_t;

    function automatic logic is_canonical(input logic [DATA_W-1:0] v);
        logic [DATA_W-VA_BITS:0] top;
        top = v[DATA_W-1:VA_BITS-1];
        return (&top) | (~|top);
    endfunction

    function automatic logic [DATA_W-1:0] cap_word(input int unsigned k);
        return {32'h5A5A_0000 + k[31:0], 32'h0000_0F00 + k[31:0]};
    endfunction

endpackage

// File: rtl/msr_rtr_decode.sv
module msr_rtr_decode
    import msr_rtr_pkg::*;
#(
    parameter logic [31:0] CAP_BASE = 32'h0000_0480,
    parameter int          NUM_CAPS = 4,
    localparam int         SEL_W    = (NUM_CAPS > 1) ? $clog2(NUM_CAPS) : 1
) (
    input  logic [IDX_W-1:0]  index,
    input  logic [PRIV_W-1:0] priv,
    input  logic              feat_x2apic,
    input  logic              x2_mode,
    input  logic              feat_sysc,
    input  logic              feat_virt,
    output target_e           target,
    output logic [SEL_W-1:0]  cap_sel
);
    localparam logic [IDX_W-1:0] CAP_END = CAP_BASE + NUM_CAPS;

    logic             in_window;
    logic             in_caps;
    logic [IDX_W-1:0] cap_off;

    assign in_window = (index >= APIC_WIN_LO) && (index <= APIC_WIN_HI);
    assign in_caps   = (index >= CAP_BASE) && (index < CAP_END);
    assign cap_off   = index - CAP_BASE;
    assign cap_sel   = cap_off[SEL_W-1:0];

    always_comb begin
        if (priv != '0)
            target = TGT_PRIV_DENY;
        else if (feat_x2apic && in_window)
            target = x2_mode ? TGT_APIC : TGT_APIC_DENY;
        else if (index == IDX_FEAT_CTL)
            target = feat_virt ? TGT_FEAT_CTL : TGT_UNKNOWN;
        else if (index == IDX_SYS_TARGET)
            target = feat_sysc ? TGT_SYS_TARGET : TGT_UNKNOWN;
        else if (in_caps)
            target = feat_virt ? TGT_CAP : TGT_UNKNOWN;
        else
            target = TGT_UNKNOWN;
    end
endmodule

// File: rtl/msr_rtr_store.sv
module msr_rtr_store
    import msr_rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              write,
    input  target_e           target,
    input  logic [DATA_W-1:0] wdata,
    output logic [31:0]       feat_ctl,
    output logic [DATA_W-1:0] sys_target,
    output logic              reject
);
    logic hit_ctl;
    logic hit_tgt;
    logic ctl_ok;
    logic tgt_ok;

    assign hit_ctl = valid && write && (target == TGT_FEAT_CTL);
    assign hit_tgt = valid && write && (target == TGT_SYS_TARGET);
    assign ctl_ok  = !feat_ctl[0];
    assign tgt_ok  = is_canonical(wdata);
    assign reject  = (hit_ctl && !ctl_ok) || (hit_tgt && !tgt_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            feat_ctl   <= '0;
            sys_target <= '0;
        end else begin
            if (hit_ctl && ctl_ok)
                feat_ctl <= wdata[31:0];
            if (hit_tgt && tgt_ok)
                sys_target <= wdata;
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        feat_ctl[0] |=> $stable(feat_ctl)); // R6

    AST_TARGET_CANONICAL: assert property (@(posedge clk) disable iff (rst)
        (&sys_target[63:47]) || (~|sys_target[63:47])); // R8
endmodule

// File: rtl/msr_router.sv
module msr_router
    import msr_rtr_pkg::*;
#(
    parameter logic [31:0] CAP_BASE = 32'h0000_0480,
    parameter int          NUM_CAPS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_index,
    input  logic [31:0] wr_hi,
    input  logic [31:0] wr_lo,
    input  logic [1:0]  req_priv,
    input  logic        feat_x2apic,
    input  logic        feat_sysc,
    input  logic        feat_virt,
    input  logic        ignore_unknown,
    input  logic        apic_x2_mode,
    output logic        apic_req,
    output logic        apic_we,
    output logic [31:0] apic_index,
    output logic [63:0] apic_wdata,
    input  logic [63:0] apic_rdata,
    input  logic        apic_fault,
    output logic        rsp_done,
    output logic        rsp_fault,
    output logic [31:0] rd_hi,
    output logic [31:0] rd_lo
);
    localparam int SEL_W = (NUM_CAPS > 1) ? $clog2(NUM_CAPS) : 1;

    target_e           target;
    logic [SEL_W-1:0]  cap_sel;
    logic [31:0]       feat_ctl;
    logic [DATA_W-1:0] sys_target;
    logic              store_reject;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] cap_rom [NUM_CAPS];
    logic              nxt_fault;
    word64_t           nxt_data;
    word64_t           rsp_data;

    assign wdata = {wr_hi, wr_lo};

    for (genvar k = 0; k < NUM_CAPS; k++) begin : g_cap
        assign cap_rom[k] = cap_word(k);
    end

    msr_rtr_decode #(.CAP_BASE(CAP_BASE), .NUM_CAPS(NUM_CAPS)) u_dec (
        .index       (req_index),
        .priv        (req_priv),
        .feat_x2apic (feat_x2apic),
        .x2_mode     (apic_x2_mode),
        .feat_sysc   (feat_sysc),
        .feat_virt   (feat_virt),
        .target      (target),
        .cap_sel     (cap_sel)
    );

    msr_rtr_store u_store (
        .clk        (clk),
        .rst        (rst),
        .valid      (req_valid),
        .write      (req_write),
        .target     (target),
        .wdata      (wdata),
        .feat_ctl   (feat_ctl),
        .sys_target (sys_target),
        .reject     (store_reject)
    );

    assign apic_req   = req_valid && (target == TGT_APIC);
    assign apic_we    = apic_req && req_write;
    assign apic_index = req_index;
    assign apic_wdata = wdata;

    always_comb begin
        nxt_fault = 1'b0;
        nxt_data  = '0;
        unique case (target)
            TGT_PRIV_DENY, TGT_APIC_DENY: nxt_fault = 1'b1;
            TGT_APIC: begin
                nxt_fault = apic_fault;
                if (!req_write && !apic_fault) nxt_data = apic_rdata;
            end
            TGT_FEAT_CTL: begin
                nxt_fault = store_reject;
                if (!req_write) nxt_data = {32'h0, feat_ctl};
            end
            TGT_SYS_TARGET: begin
                nxt_fault = store_reject;
                if (!req_write) nxt_data = sys_target;
            end
            TGT_CAP: begin
                nxt_fault = req_write;
                if (!req_write) nxt_data = cap_rom[cap_sel];
            end
            default: nxt_fault = !ignore_unknown;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_done  <= req_valid;
            rsp_fault <= req_valid && nxt_fault;
            rsp_data  <= req_valid ? nxt_data : '0;
        end
    end

    assign rd_hi = rsp_data.hi;
    assign rd_lo = rsp_data.lo;

    AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv != 2'd0) |=> (rsp_done && rsp_fault)); // R1

    AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rd_hi == 32'h0 && rd_lo == 32'h0)); // R2

    AST_APIC_GATED: assert property (@(posedge clk) disable iff (rst)
        apic_req |-> (req_priv == 2'd0 && feat_x2apic && apic_x2_mode)); // R3

    AST_CAP_WRITE_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && target == TGT_CAP) |=> rsp_fault); // R7

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_done); // R9
endmodule

// File: tb/msr_router_test.sv
module msr_router_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] IDX_CTL = 32'h0000_003A;
    localparam logic [31:0] IDX_TGT = 32'hC000_0082;
    localparam logic [31:0] IDX_CAP = 32'h0000_0480;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_index = '0, wr_hi = '0, wr_lo = '0;
    logic [1:0] req_priv = '0;
    logic feat_x2apic = 1'b0, feat_sysc = 1'b1, feat_virt = 1'b1;
    logic ignore_unknown = 1'b0, apic_x2_mode = 1'b0;
    logic apic_req, apic_we;
    logic [31:0] apic_index;
    logic [63:0] apic_wdata, apic_rdata;
    logic apic_fault;
    logic rsp_done, rsp_fault;
    logic [31:0] rd_hi, rd_lo;

    int vectors = 0;
    int misses = 0;
    logic finished = 1'b0;

    logic [63:0] got_data;
    logic got_fault, got_done, saw_apic, saw_apic_we;
    logic [63:0] saw_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign apic_rdata = {32'hA11C_0000, apic_index};
    assign apic_fault = (apic_index == 32'h0000_0BFF);

    msr_router uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .wr_hi(wr_hi), .wr_lo(wr_lo), .req_priv(req_priv),
        .feat_x2apic(feat_x2apic), .feat_sysc(feat_sysc), .feat_virt(feat_virt),
        .ignore_unknown(ignore_unknown), .apic_x2_mode(apic_x2_mode),
        .apic_req(apic_req), .apic_we(apic_we), .apic_index(apic_index),
        .apic_wdata(apic_wdata), .apic_rdata(apic_rdata), .apic_fault(apic_fault),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rd_hi(rd_hi), .rd_lo(rd_lo)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xact(input logic w, input logic [31:0] idx, input logic [63:0] val,
                        input logic [1:0] pl);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_index = idx;
        wr_hi = val[63:32]; wr_lo = val[31:0]; req_priv = pl;
        #1;
        saw_apic = apic_req; saw_apic_we = apic_we; saw_wdata = apic_wdata;
        @(negedge clk);
        req_valid = 1'b0;
        got_data = {rd_hi, rd_lo}; got_fault = rsp_fault; got_done = rsp_done;
        check("R9 done strobe", {63'h0, got_done}, 64'h1);
    endtask

    task automatic test_reset();
        check("R9 idle after reset", {63'h0, rsp_done}, 64'h0);
        xact(1'b0, IDX_CTL, '0, 2'd0);
        check("R6 reset value", got_data, 64'h0);
        check("R6 reset no fault", {63'h0, got_fault}, 64'h0);
        xact(1'b0, IDX_TGT, '0, 2'd0);
        check("R8 reset value", got_data, 64'h0);
    endtask

    task automatic test_halves();
        xact(1'b1, IDX_TGT, 64'hFFFF_8000_1234_5678, 2'd0);
        check("R2 write ok", {63'h0, got_fault}, 64'h0);
        xact(1'b0, IDX_TGT, '0, 2'd0);
        check("R2 rd_hi", {32'h0, got_data[63:32]}, 64'hFFFF_8000);
        check("R2 rd_lo", {32'h0, got_data[31:0]}, 64'h1234_5678);
    endtask

    task automatic test_priv();
        xact(1'b1, IDX_TGT, 64'h0000_0000_0000_1111, 2'd3);
        check("R1 write at pl3 faults", {63'h0, got_fault}, 64'h1);
        xact(1'b0, IDX_TGT, '0, 2'd2);
        check("R1 read at pl2 faults", {63'h0, got_fault}, 64'h1);
        check("R1 faulting read zero", got_data, 64'h0);
        xact(1'b0, IDX_TGT, '0, 2'd0);
        check("R1 register unchanged", got_data, 64'hFFFF_8000_1234_5678);
        feat_x2apic = 1'b1; apic_x2_mode = 1'b1;
        xact(1'b0, 32'h830, '0, 2'd1);
        check("R1 no apic request", {63'h0, saw_apic}, 64'h0);
        feat_x2apic = 1'b0; apic_x2_mode = 1'b0;
    endtask

    task automatic test_canon();
        xact(1'b1, IDX_TGT, 64'h0000_8000_0000_0000, 2'd0);
        check("R8 non-canonical faults", {63'h0, got_fault}, 64'h1);
        xact(1'b0, IDX_TGT, '0, 2'd0);
        check("R8 unchanged", got_data, 64'hFFFF_8000_1234_5678);
        xact(1'b1, IDX_TGT, 64'h0000_7FFF_FFFF_F000, 2'd0);
        check("R8 canonical accepted", {63'h0, got_fault}, 64'h0);
        xact(1'b0, IDX_TGT, '0, 2'd0);
        check("R8 stored", got_data, 64'h0000_7FFF_FFFF_F000);
    endtask

    task automatic test_apic();
        feat_x2apic = 1'b1; apic_x2_mode = 1'b1;
        xact(1'b0, 32'h830, '0, 2'd0);
        check("R3 apic request", {63'h0, saw_apic}, 64'h1);
        check("R3 apic data", got_data, 64'hA11C_0000_0000_0830);
        check("R3 no fault", {63'h0, got_fault}, 64'h0);
        xact(1'b1, 32'h808, 64'h0102_0304_0506_0708, 2'd0);
        check("R3 apic write flag", {63'h0, saw_apic_we}, 64'h1);
        check("R3 apic write value", saw_wdata, 64'h0102_0304_0506_0708);
        xact(1'b0, 32'hBFF, '0, 2'd0);
        check("R3 apic fault passed", {63'h0, got_fault}, 64'h1);
        apic_x2_mode = 1'b0;
        xact(1'b0, 32'h830, '0, 2'd0);
        check("R3 mode off faults", {63'h0, got_fault}, 64'h1);
        check("R3 mode off port idle", {63'h0, saw_apic}, 64'h0);
        feat_x2apic = 1'b0; ignore_unknown = 1'b1;
        xact(1'b0, 32'h830, '0, 2'd0);
        check("R3 window disabled is unknown", {got_fault, got_data[62:0]}, 64'h0);
        check("R3 window disabled port idle", {63'h0, saw_apic}, 64'h0);
        ignore_unknown = 1'b0;
    endtask

    task automatic test_unknown();
        xact(1'b0, 32'h1234, '0, 2'd0);
        check("R5 unknown read faults", {63'h0, got_fault}, 64'h1);
        xact(1'b0, IDX_CAP + 32'd4, '0, 2'd0);
        check("R5 past cap range unknown", {63'h0, got_fault}, 64'h1);
        ignore_unknown = 1'b1;
        xact(1'b0, 32'h1234, '0, 2'd0);
        check("R5 ignored read fault", {63'h0, got_fault}, 64'h0);
        check("R5 ignored read zero", got_data, 64'h0);
        xact(1'b1, 32'h1234, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0);
        check("R5 ignored write", {63'h0, got_fault}, 64'h0);
        ignore_unknown = 1'b0;
    endtask

    task automatic test_gate();
        feat_sysc = 1'b0;
        xact(1'b0, IDX_TGT, '0, 2'd0);
        check("R4 gated read faults", {63'h0, got_fault}, 64'h1);
        ignore_unknown = 1'b1;
        xact(1'b1, IDX_TGT, 64'h0000_0000_0000_ABCD, 2'd0);
        check("R4 gated write dropped quietly", {63'h0, got_fault}, 64'h0);
        ignore_unknown = 1'b0; feat_sysc = 1'b1;
        xact(1'b0, IDX_TGT, '0, 2'd0);
        check("R4 value kept", got_data, 64'h0000_7FFF_FFFF_F000);
        feat_virt = 1'b0;
        xact(1'b0, IDX_CAP, '0, 2'd0);
        check("R4 gated cap faults", {63'h0, got_fault}, 64'h1);
        xact(1'b0, IDX_CTL, '0, 2'd0);
        check("R4 gated ctl faults", {63'h0, got_fault}, 64'h1);
        feat_virt = 1'b1;
    endtask

    task automatic test_caps();
        for (int k = 0; k < 4; k++) begin
            xact(1'b0, IDX_CAP + k, '0, 2'd0);
            check("R7 cap value", got_data,
                  {32'h5A5A_0000 + k, 32'h0000_0F00 + k});
        end
        xact(1'b1, IDX_CAP + 32'd1, 64'h0, 2'd0);
        check("R7 cap write faults", {63'h0, got_fault}, 64'h1);
        xact(1'b0, IDX_CAP + 32'd1, '0, 2'd0);
        check("R7 cap unchanged", got_data, 64'h5A5A_0001_0000_0F01);
    endtask

    task automatic test_lock();
        xact(1'b1, IDX_CTL, 64'hDEAD_BEEF_0000_0004, 2'd0);
        check("R6 write accepted", {63'h0, got_fault}, 64'h0);
        xact(1'b0, IDX_CTL, '0, 2'd0);
        check("R6 low half only", got_data, 64'h0000_0000_0000_0004);
        xact(1'b1, IDX_CTL, 64'h0000_0000_0000_0005, 2'd0);
        check("R6 locking write", {63'h0, got_fault}, 64'h0);
        xact(1'b1, IDX_CTL, 64'h0, 2'd0);
        check("R6 locked write faults", {63'h0, got_fault}, 64'h1);
        xact(1'b0, IDX_CTL, '0, 2'd0);
        check("R6 locked value", got_data, 64'h5);
        @(negedge clk);
        check("R9 done drops", {63'h0, rsp_done}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_halves();
        test_priv();
        test_canon();
        test_apic();
        test_unknown();
        test_gate();
        test_caps();
        test_lock();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule